// File: doc/BRIEF.md
# Rotate, Shift and Bit Unit

This block is the combinational rotate, shift, nibble-swap and single-bit engine of an 8-bit accumulator CPU execution stage. Each cycle the core presents one operand, an operation code, a bit index, the current Carry flag and a marker for the short accumulator-only rotate encodings. The block returns the new operand value with a result write-enable, and the four new flags (Zero, Subtract, Half-carry, Carry) with a per-flag write mask. Operand fetch and write-back stay in the surrounding core.

A small decoder turns the operation code into a struct of strobes: shift direction, fill source, zero-forcing, swap and the bit strobes. The datapath applies them to the operand. No state is held. A change at the inputs reaches the outputs in the same cycle.

Top module: `rsb_unit`

## Requirements
- R1: Operation codes are 0 rotate-left circular, 1 rotate-right circular, 2 rotate-left through carry, 3 rotate-right through carry, 4 shift left, 5 arithmetic shift right, 6 logical shift right, 7 swap, 8 bit test, 9 bit reset, 10 bit set, 11 to 15 no operation. Code 0 moves bit 7 into bit 0. Code 1 moves bit 0 into bit 7.
- R2: Code 2 puts `carryIn` into bit 0 and code 3 puts `carryIn` into bit 7. The other bits move by one place.
- R3: Code 4 puts 0 into bit 0. Code 5 keeps bit 7 at its old value. Code 6 puts 0 into bit 7.
- R4: For codes 0 to 6, `flagC` is the bit shifted out (bit 7 for left moves, bit 0 for right moves), `flagN` and `flagH` are 0, `flagWe` is 4'b1111 and `resultWe` is 1.
- R5: For codes 0 to 3 with `accShort` high, `flagZ` is 0. For codes 0 to 6 otherwise, `flagZ` is 1 exactly when the result is 0. `accShort` has no effect on codes 4 to 15.
- R6: Code 7 exchanges bits 7:4 with bits 3:0. It sets `flagZ` from the result, clears `flagC`, `flagN` and `flagH`, and drives `flagWe` 4'b1111 and `resultWe` 1.
- R7: Code 8 sets `flagZ` to the inverse of operand bit `bitIdx`, with `flagN` 0, `flagH` 1 and `flagC` equal to `carryIn`. `flagWe` is 4'b1110 (bit order Z,N,H,C from MSB). `resultWe` is 0.
- R8: Codes 9 and 10 clear or set only bit `bitIdx`. `resultWe` is 1 and `flagWe` is 0.
- R9: Whenever `resultWe` is 0, `result` equals `operand`. For codes 11 to 15, `resultWe` and `flagWe` are 0. Any flag whose mask bit is 0 drives 0, except `flagC`, which drives `carryIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | 8 | Operand value |
| opSel | input | 4 | Operation code |
| bitIdx | input | 3 | Bit index for bit test, reset and set |
| carryIn | input | 1 | Current Carry flag |
| accShort | input | 1 | Marks a short accumulator-only rotate |
| result | output | 8 | New operand value |
| resultWe | output | 1 | Result should be written back |
| flagZ | output | 1 | New Zero flag |
| flagN | output | 1 | New Subtract flag |
| flagH | output | 1 | New Half-carry flag |
| flagC | output | 1 | New Carry flag |
| flagWe | output | 4 | Flag write mask, Z,N,H,C from MSB |

## Verification
The embedded immediate checks assume that every input carries a known 0 or 1 value. Each check is gated on the inputs having no unknown bits, so it stays silent before the bench first drives the port. The bench drives every input on the falling edge from the start of reset, and it never leaves an input floating. It sweeps all sixteen codes over both Carry values, both short markers and boundary operands such as 0x00, 0x01, 0x80 and 0xFF.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

  typedef enum logic [3:0] {
    OP_RLC  = 4'd0,
    OP_RRC  = 4'd1,
    OP_RL   = 4'd2,
    OP_RR   = 4'd3,
    OP_SLA  = 4'd4,
    OP_SRA  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SWAP = 4'd7,
    OP_BTST = 4'd8,
    OP_BCLR = 4'd9,
    OP_BSET = 4'd10
  } rsbOp_e;

  typedef enum logic [1:0] {
    FILL_ZERO  = 2'd0,
    FILL_WRAP  = 2'd1,
    FILL_CARRY = 2'd2,
    FILL_SIGN  = 2'd3
  } fill_e;

  typedef struct packed {
    logic       shLeft;
    logic       shRight;
    fill_e      fill;
    logic       zeroForce;
    logic       swapOp;
    logic       bitTest;
    logic       bitClr;
    logic       bitSet;
    logic       resultWe;
    logic [3:0] flagWe;
  } rsbCtl_t;

endpackage

// File: rtl/rsb_ctrl.sv
module rsb_ctrl
  import rsb_pkg::*;
(
  input  logic [3:0] opSel,
  input  logic       accShort,
  output rsbCtl_t    ctl
);

  always_comb begin
    ctl = '0;
    case (opSel)
      OP_RLC: begin
        ctl.shLeft = 1'b1; ctl.fill = FILL_WRAP; ctl.zeroForce = accShort;
        ctl.resultWe = 1'b1; ctl.flagWe = 4'hF;
      end
      OP_RRC: begin
        ctl.shRight = 1'b1; ctl.fill = FILL_WRAP; ctl.zeroForce = accShort;
        ctl.resultWe = 1'b1; ctl.flagWe = 4'hF;
      end
      OP_RL: begin
        ctl.shLeft = 1'b1; ctl.fill = FILL_CARRY; ctl.zeroForce = accShort;
        ctl.resultWe = 1'b1; ctl.flagWe = 4'hF;
      end
      OP_RR: begin
        ctl.shRight = 1'b1; ctl.fill = FILL_CARRY; ctl.zeroForce = accShort;
        ctl.resultWe = 1'b1; ctl.flagWe = 4'hF;
      end
      OP_SLA: begin
        ctl.shLeft = 1'b1; ctl.fill = FILL_ZERO;
        ctl.resultWe = 1'b1; ctl.flagWe = 4'hF;
      end
      OP_SRA: begin
        ctl.shRight = 1'b1; ctl.fill = FILL_SIGN;
        ctl.resultWe = 1'b1; ctl.flagWe = 4'hF;
      end
      OP_SRL: begin
        ctl.shRight = 1'b1; ctl.fill = FILL_ZERO;
        ctl.resultWe = 1'b1; ctl.flagWe = 4'hF;
      end
      OP_SWAP: begin
        ctl.swapOp = 1'b1; ctl.resultWe = 1'b1; ctl.flagWe = 4'hF;
      end
      OP_BTST: begin
        ctl.bitTest = 1'b1; ctl.flagWe = 4'b1110;
      end
      OP_BCLR: begin
        ctl.bitClr = 1'b1; ctl.resultWe = 1'b1;
      end
      OP_BSET: begin
        ctl.bitSet = 1'b1; ctl.resultWe = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

  // R1: at most one operation strobe is active for any code
  always_comb begin
    if (!$isunknown({opSel, accShort})) begin
      a_r1_one_strobe: assert ($onehot0({ctl.shLeft, ctl.shRight, ctl.swapOp,
                                         ctl.bitTest, ctl.bitClr, ctl.bitSet}));
    end
  end

  // R5: zero forcing only ever accompanies a rotate
  always_comb begin
    if (!$isunknown({opSel, accShort}) && ctl.zeroForce) begin
      a_r5_force_on_rotate: assert (ctl.shLeft || ctl.shRight);
    end
  end

endmodule

// File: rtl/rsb_datapath.sv
module rsb_datapath
  import rsb_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDXW = $clog2(WIDTH),
  localparam int HALF = WIDTH / 2
) (
  input  logic [WIDTH-1:0] operand,
  input  logic [IDXW-1:0]  bitIdx,
  input  logic             carryIn,
  input  rsbCtl_t          ctl,
  output logic [WIDTH-1:0] result,
  output logic             flagZ,
  output logic             flagN,
  output logic             flagH,
  output logic             flagC
);

  logic [WIDTH-1:0] bitMask;
  logic             fillLow;
  logic             fillHigh;
  logic             shiftOut;
  logic             selBit;

  for (genvar g = 0; g < WIDTH; g++) begin : g_mask
    assign bitMask[g] = (bitIdx == IDXW'(g));
  end

  assign selBit = |(operand & bitMask);

  always_comb begin
    fillLow  = 1'b0;
    fillHigh = 1'b0;
    case (ctl.fill)
      FILL_WRAP:  begin fillLow = operand[WIDTH-1]; fillHigh = operand[0]; end
      FILL_CARRY: begin fillLow = carryIn;          fillHigh = carryIn;    end
      FILL_SIGN:  begin fillLow = 1'b0;             fillHigh = operand[WIDTH-1]; end
      default:    begin fillLow = 1'b0;             fillHigh = 1'b0;       end
    endcase
  end

  always_comb begin
    result   = operand;
    shiftOut = 1'b0;
    if (ctl.shLeft) begin
      result   = {operand[WIDTH-2:0], fillLow};
      shiftOut = operand[WIDTH-1];
    end else if (ctl.shRight) begin
      result   = {fillHigh, operand[WIDTH-1:1]};
      shiftOut = operand[0];
    end else if (ctl.swapOp) begin
      result = {operand[HALF-1:0], operand[WIDTH-1:HALF]};
    end else if (ctl.bitClr) begin
      result = operand & ~bitMask;
    end else if (ctl.bitSet) begin
      result = operand | bitMask;
    end
  end

  always_comb begin
    flagZ = 1'b0;
    flagN = 1'b0;
    flagH = 1'b0;
    flagC = carryIn;
    if (ctl.shLeft || ctl.shRight) begin
      flagZ = ~ctl.zeroForce & (result == '0);
      flagC = shiftOut;
    end else if (ctl.swapOp) begin
      flagZ = (result == '0);
      flagC = 1'b0;
    end else if (ctl.bitTest) begin
      flagZ = ~selBit;
      flagH = 1'b1;
    end
  end

  // R8: a bit reset or set touches at most one bit of the operand
  always_comb begin
    if (!$isunknown({operand, bitIdx, carryIn, ctl}) && (ctl.bitClr || ctl.bitSet)) begin
      a_r8_single_bit: assert ($countones(result ^ operand) <= 1);
    end
  end

  // R1: a circular rotate keeps the number of set bits
  always_comb begin
    if (!$isunknown({operand, bitIdx, carryIn, ctl}) &&
        (ctl.shLeft || ctl.shRight) && ctl.fill == FILL_WRAP) begin
      a_r1_rotate_popcount: assert ($countones(result) == $countones(operand));
    end
  end

  // R6: a nibble swap keeps the number of set bits
  always_comb begin
    if (!$isunknown({operand, bitIdx, carryIn, ctl}) && ctl.swapOp) begin
      a_r6_swap_popcount: assert ($countones(result) == $countones(operand));
    end
  end

  // R5: a short accumulator rotate never reports Zero
  always_comb begin
    if (!$isunknown({operand, bitIdx, carryIn, ctl}) && ctl.zeroForce) begin
      a_r5_short_no_zero: assert (!flagZ);
    end
  end

endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
(
  input  logic [7:0] operand,
  input  logic [3:0] opSel,
  input  logic [2:0] bitIdx,
  input  logic       carryIn,
  input  logic       accShort,
  output logic [7:0] result,
  output logic       resultWe,
  output logic       flagZ,
  output logic       flagN,
  output logic       flagH,
  output logic       flagC,
  output logic [3:0] flagWe
);

  rsbCtl_t ctl;

  rsb_ctrl u_ctrl (
    .opSel    (opSel),
    .accShort (accShort),
    .ctl      (ctl)
  );

  rsb_datapath #(.WIDTH(8)) u_dp (
    .operand (operand),
    .bitIdx  (bitIdx),
    .carryIn (carryIn),
    .ctl     (ctl),
    .result  (result),
    .flagZ   (flagZ),
    .flagN   (flagN),
    .flagH   (flagH),
    .flagC   (flagC)
  );

  assign resultWe = ctl.resultWe;
  assign flagWe   = ctl.flagWe;

  // R9: no write back means the operand passes through untouched
  always_comb begin
    if (!$isunknown({operand, opSel, bitIdx, carryIn, accShort}) && !resultWe) begin
      a_r9_pass_through: assert (result == operand);
    end
  end

endmodule

// File: tb/rsb_unit_test.sv
module rsb_unit_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] operand = 8'h00;
  logic [3:0] opSel = 4'd15;
  logic [2:0] bitIdx = 3'd0;
  logic       carryIn = 1'b0;
  logic       accShort = 1'b0;
  logic [7:0] result;
  logic       resultWe, flagZ, flagN, flagH, flagC;
  logic [3:0] flagWe;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] res;
    logic       rwe;
    logic [3:0] flags;
    logic [3:0] fwe;
    string      resTag;
    string      zTag;
    string      cTag;
    string      ctlTag;
  } expItem_t;

  expItem_t sb[$];

  always #5 clk = ~clk;

  rsb_unit uut (
    .operand(operand), .opSel(opSel), .bitIdx(bitIdx), .carryIn(carryIn),
    .accShort(accShort), .result(result), .resultWe(resultWe), .flagZ(flagZ),
    .flagN(flagN), .flagH(flagH), .flagC(flagC), .flagWe(flagWe)
  );

  function automatic expItem_t model(logic [3:0] op, logic [7:0] a, logic [2:0] idx,
                                     logic cin, logic sh);
    expItem_t e;
    logic z, n, h, c;
    e.res = a; e.rwe = 1'b0; e.fwe = 4'b0000;
    z = 1'b0; n = 1'b0; h = 1'b0; c = cin;
    e.resTag = "R9"; e.zTag = "R9"; e.cTag = "R9"; e.ctlTag = "R9";
    if (op <= 4'd6) begin
      case (op)
        4'd0: begin e.res = {a[6:0], a[7]}; c = a[7]; e.resTag = "R1"; end
        4'd1: begin e.res = {a[0], a[7:1]}; c = a[0]; e.resTag = "R1"; end
        4'd2: begin e.res = {a[6:0], cin};  c = a[7]; e.resTag = "R2"; end
        4'd3: begin e.res = {cin, a[7:1]};  c = a[0]; e.resTag = "R2"; end
        4'd4: begin e.res = {a[6:0], 1'b0}; c = a[7]; e.resTag = "R3"; end
        4'd5: begin e.res = {a[7], a[7:1]}; c = a[0]; e.resTag = "R3"; end
        default: begin e.res = {1'b0, a[7:1]}; c = a[0]; e.resTag = "R3"; end
      endcase
      z = (op <= 4'd3 && sh) ? 1'b0 : (e.res == 8'h00);
      e.rwe = 1'b1; e.fwe = 4'b1111;
      e.zTag = "R5"; e.cTag = "R4"; e.ctlTag = "R4";
    end else if (op == 4'd7) begin
      e.res = {a[3:0], a[7:4]}; z = (e.res == 8'h00); c = 1'b0;
      e.rwe = 1'b1; e.fwe = 4'b1111;
      e.resTag = "R6"; e.zTag = "R6"; e.cTag = "R6"; e.ctlTag = "R6";
    end else if (op == 4'd8) begin
      z = ~a[idx]; h = 1'b1; e.fwe = 4'b1110;
      e.resTag = "R7"; e.zTag = "R7"; e.cTag = "R7"; e.ctlTag = "R7";
    end else if (op == 4'd9 || op == 4'd10) begin
      e.res = a; e.res[idx] = (op == 4'd10); e.rwe = 1'b1;
      e.resTag = "R8"; e.zTag = "R8"; e.cTag = "R8"; e.ctlTag = "R8";
    end
    e.flags = {z, n, h, c};
    return e;
  endfunction

  task automatic apply(logic [3:0] op, logic [7:0] a, logic [2:0] idx, logic cin, logic sh);
    @(negedge clk);
    opSel = op; operand = a; bitIdx = idx; carryIn = cin; accShort = sh;
    sb.push_back(model(op, a, idx, cin, sh));
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h (op %0d operand %02h idx %0d cin %0b short %0b)",
               tag, what, act, exp, opSel, operand, bitIdx, carryIn, accShort);
    end
  endtask

  // monitor: pops one expected item per rising edge
  always @(posedge clk) begin
    if (sb.size() > 0) begin
      expItem_t e;
      e = sb.pop_front();
      chk(e.resTag, "result", result, e.res);
      chk(e.ctlTag, "resultWe", resultWe, e.rwe);
      chk(e.ctlTag, "flagWe", flagWe, e.fwe);
      chk(e.zTag, "flagZ", flagZ, e.flags[3]);
      chk(e.ctlTag, "flagN", flagN, e.flags[2]);
      chk(e.ctlTag, "flagH", flagH, e.flags[1]);
      chk(e.cTag, "flagC", flagC, e.flags[0]);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      testsRun++; testsFailed++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [10] = '{8'h00, 8'h01, 8'h80, 8'h81, 8'h7F, 8'hFF, 8'hA5, 8'h3C, 8'hF0, 8'h0F};
    // reset state: idle code, R9
    apply(4'd15, 8'h5A, 3'd2, 1'b1, 1'b0);
    apply(4'd15, 8'h5A, 3'd2, 1'b0, 1'b0);
    @(negedge clk); rst = 1'b0;
    // R1 R2 R3 corner cases
    apply(4'd0, 8'h80, 3'd0, 1'b0, 1'b0);
    apply(4'd1, 8'h01, 3'd0, 1'b0, 1'b0);
    apply(4'd2, 8'h80, 3'd0, 1'b1, 1'b0);
    apply(4'd3, 8'h01, 3'd0, 1'b0, 1'b0);
    apply(4'd5, 8'h81, 3'd0, 1'b0, 1'b0);
    apply(4'd6, 8'h01, 3'd0, 1'b0, 1'b0);
    apply(4'd4, 8'h80, 3'd0, 1'b1, 1'b1);
    // R5 short rotate of zero result
    apply(4'd2, 8'h80, 3'd0, 1'b0, 1'b1);
    apply(4'd0, 8'h00, 3'd0, 1'b0, 1'b1);
    // R6 R7 R8
    apply(4'd7, 8'hF0, 3'd0, 1'b1, 1'b0);
    apply(4'd7, 8'h00, 3'd0, 1'b1, 1'b0);
    apply(4'd8, 8'h7F, 3'd7, 1'b1, 1'b0);
    apply(4'd8, 8'h80, 3'd7, 1'b0, 1'b0);
    apply(4'd9, 8'hFF, 3'd3, 1'b0, 1'b0);
    apply(4'd10, 8'h00, 3'd6, 1'b1, 1'b0);
    // sweep of every code
    for (int op = 0; op < 16; op++)
      for (int p = 0; p < 10; p++)
        for (int ci = 0; ci < 2; ci++)
          for (int s = 0; s < 2; s++)
            apply(4'(op), pats[p], 3'((p * 3 + op + ci) % 8), 1'(ci), 1'(s));
    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule